// File: doc/BRIEF.md
# Queue-Occupancy Voltage/Frequency Level Controller

This block sits beside a decoupling queue that carries work from a producer clock domain (geometry side) to a consumer clock domain (pixel side). It samples the queue's current fill count against its capacity on every clock. From those samples it chooses a voltage/frequency setting for each domain. A queue that stays close to full shows that the producer is running ahead, so the producer can be slowed. A queue that stays close to empty shows that the consumer is waiting for work, so the consumer can be slowed.

Reductions come only after a long dwell, which avoids paying for frequent switches. Each reduction is one tenth of the full setting. A domain returns to full at once when the queue reaches the opposite watermark, because that shows the slowed domain has become the bottleneck. Each change of setting raises a stall output for a programmable number of cycles, which covers the time the supply and clock need to settle.

Top module: `occ_dvs_ctrl`

## Requirements
- R1: After reset, both level outputs hold code 10, which means the full setting, and `stall` is low. Level codes count in tenths of full, so 9 means 90%.
- R2: A sample is in the near-full band when occ*10 >= cap*9. It is in the near-empty band when occ*10 <= cap. If both conditions hold, the sample counts as near-full. Any other sample is outside both bands.
- R3: When DWELL_CYC consecutive samples fall in the near-full band, the producer level drops by exactly one code on the clock edge that takes the last of those samples. The consumer level does not change.
- R4: When DWELL_CYC consecutive samples fall in the near-empty band, the consumer level drops by one code in the same way. The producer level does not change.
- R5: A sample outside the band, or in the other band, discards the run count. A fresh run of DWELL_CYC samples is then needed before any reduction.
- R6: After a reduction, the run count restarts from zero. A further reduction therefore needs DWELL_CYC more samples in the same band.
- R7: A reduction never takes a level below `floor_lvl`. A `floor_lvl` above 10 is treated as 10, and a value of 0 is treated as 1.
- R8: While the producer level is below 10, a near-empty sample returns it to 10 on that edge. While the consumer level is below 10, a near-full sample returns the consumer to 10 on that edge.
- R9: On every edge that changes either level, the stall counter loads `stall_len`. `stall` is then high for exactly `stall_len` cycles. A value of 0 gives no stall. A change during a stall reloads the full length.
- R10: `stall` never rises on an edge that changes no level. This includes a reduction that is refused because the level is already at the floor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Active-low synchronous reset |
| occ | input | OCC_W | Current queue fill count |
| cap | input | OCC_W | Queue capacity |
| floor_lvl | input | 4 | Lowest level code a reduction may reach |
| stall_len | input | STALL_W | Settle period in cycles for each change |
| prod_lvl | output | 4 | Producer domain level code (10 = full) |
| cons_lvl | output | 4 | Consumer domain level code (10 = full) |
| stall | output | 1 | High while a level change is settling |

## Verification
The hardest case to reach from the ports is a second level change that lands while an earlier stall is still counting. This needs a stall longer than the dwell period. The bench therefore builds the design with a short dwell and drives a stall length longer than that dwell. It then keeps the queue near full across two reductions and expects the stall to end one full length after the second one. The floor clamp and the priority between the two bands also depend on a long history, so the bench reaches them in one continuous sequence. That sequence walks the levels down step by step, and its expected values are tracked as it goes.

// File: rtl/occ_dvs_pkg.sv
package occ_dvs_pkg;

   // Occupancy classification of one sample
   typedef enum logic [1:0] {
      BAND_NONE  = 2'd0,
      BAND_FULL  = 2'd1,
      BAND_EMPTY = 2'd2
   } band_t;

   localparam int LVL_W = 4;
   typedef logic [LVL_W-1:0] lvl_t;

   // Level codes are in tenths of the full setting
   localparam lvl_t LVL_FULL = 4'd10;
   localparam lvl_t LVL_MIN  = 4'd1;

   localparam int NUM_DOM = 2;
   localparam int DOM_PROD = 0;
   localparam int DOM_CONS = 1;

endpackage

// File: rtl/occ_band_detect.sv
module occ_band_detect
   import occ_dvs_pkg::*;
#(
   parameter int OCC_W       = 8,
   parameter int BAND_TENTHS = 1
) (
   input  logic [OCC_W-1:0] occ,
   input  logic [OCC_W-1:0] cap,
   output band_t            band
);

   localparam int PW     = OCC_W + 4;
   localparam int HI_MUL = 10 - BAND_TENTHS;

   if (OCC_W < 2) begin : g_bad_w
      $error("occ_band_detect: OCC_W must be at least 2");
   end
   if (BAND_TENTHS < 1 || BAND_TENTHS > 4) begin : g_bad_band
      $error("occ_band_detect: BAND_TENTHS must be 1..4");
   end

   logic [PW-1:0] occ_x10;
   logic [PW-1:0] hi_mark;
   logic [PW-1:0] lo_mark;
   logic          near_full;
   logic          near_empty;

   assign occ_x10 = PW'(occ) * PW'(10);
   assign hi_mark = PW'(cap) * PW'(HI_MUL);

   // The default band of one tenth needs no multiplier for the low mark
   if (BAND_TENTHS == 1) begin : g_lo_plain
      assign lo_mark = PW'(cap);
   end else begin : g_lo_mul
      assign lo_mark = PW'(cap) * PW'(BAND_TENTHS);
   end

   assign near_full  = (occ_x10 >= hi_mark);
   assign near_empty = (occ_x10 <= lo_mark);

   always_comb begin
      if (near_full)       band = BAND_FULL;
      else if (near_empty) band = BAND_EMPTY;
      else                 band = BAND_NONE;
   end

endmodule

// File: rtl/dwell_timer.sv
module dwell_timer
   import occ_dvs_pkg::*;
#(
   parameter int DWELL_CYC = 50000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  band_t band,
   output logic  step_vld,
   output band_t step_band
);

   localparam int CNT_W = $clog2(DWELL_CYC + 1);

   if (DWELL_CYC < 1) begin : g_bad_dwell
      $error("dwell_timer: DWELL_CYC must be at least 1");
   end

   band_t            band_q;
   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] run_inc;

   always_comb begin
      if (band != BAND_NONE && band == band_q) run_inc = run_q + CNT_W'(1);
      else if (band != BAND_NONE)              run_inc = CNT_W'(1);
      else                                     run_inc = '0;
      step_vld  = (band != BAND_NONE) && (run_inc == CNT_W'(DWELL_CYC));
      step_band = band;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         band_q <= BAND_NONE;
         run_q  <= '0;
      end else begin
         band_q <= band;
         run_q  <= step_vld ? '0 : run_inc;
      end
   end

   // R5
   run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q < CNT_W'(DWELL_CYC));

   // R5
   run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (band != band_q) |=> (run_q <= CNT_W'(1)));

   // R6
   run_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_vld |=> (run_q == '0));

endmodule

// File: rtl/dom_level.sv
module dom_level
   import occ_dvs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic restore,
   input  lvl_t floor_lvl,
   output lvl_t lvl,
   output logic changed
);

   lvl_t floor_c;
   lvl_t lvl_q;
   lvl_t lvl_d;

   always_comb begin
      if (floor_lvl > LVL_FULL)      floor_c = LVL_FULL;
      else if (floor_lvl < LVL_MIN)  floor_c = LVL_MIN;
      else                           floor_c = floor_lvl;
   end

   always_comb begin
      lvl_d = lvl_q;
      if (restore && lvl_q != LVL_FULL)  lvl_d = LVL_FULL;
      else if (step && lvl_q > floor_c)  lvl_d = lvl_q - 4'd1;
   end

   assign changed = (lvl_d != lvl_q);
   assign lvl     = lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= LVL_FULL;
      else        lvl_q <= lvl_d;
   end

   // R1
   lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q <= LVL_FULL) && (lvl_q >= LVL_MIN));

   // R3
   lvl_step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (lvl_q == LVL_FULL || lvl_q == $past(lvl_q) || lvl_q == ($past(lvl_q) - 4'd1)));

   // R7
   lvl_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !restore && lvl_q > floor_c) |=> (lvl_q >= $past(floor_c)));

   // R8
   lvl_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (restore && lvl_q != LVL_FULL) |=> (lvl_q == LVL_FULL));

endmodule

// File: rtl/stall_timer.sv
module stall_timer #(
   parameter int STALL_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [STALL_W-1:0] len,
   output logic               stall
);

   if (STALL_W < 1) begin : g_bad_sw
      $error("stall_timer: STALL_W must be at least 1");
   end

   logic [STALL_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= len;
      else if (cnt_q != '0)    cnt_q <= cnt_q - STALL_W'(1);
   end

   assign stall = (cnt_q != '0);

   // R9
   stall_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - STALL_W'(1)));

   // R9
   stall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(len)));

endmodule

// File: rtl/occ_dvs_ctrl.sv
module occ_dvs_ctrl
   import occ_dvs_pkg::*;
#(
   parameter int OCC_W       = 8,
   parameter int DWELL_CYC   = 50000,
   parameter int STALL_W     = 12,
   parameter int BAND_TENTHS = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [OCC_W-1:0]   occ,
   input  logic [OCC_W-1:0]   cap,
   input  logic [3:0]         floor_lvl,
   input  logic [STALL_W-1:0] stall_len,
   output logic [3:0]         prod_lvl,
   output logic [3:0]         cons_lvl,
   output logic               stall
);

   band_t               band;
   logic                step_vld;
   band_t               step_band;
   logic [NUM_DOM-1:0]  dom_step;
   logic [NUM_DOM-1:0]  dom_rest;
   logic [NUM_DOM-1:0]  dom_chg;
   lvl_t                dom_lvl [NUM_DOM];

   occ_band_detect #(
      .OCC_W       (OCC_W),
      .BAND_TENTHS (BAND_TENTHS)
   ) u_band (
      .occ  (occ),
      .cap  (cap),
      .band (band)
   );

   dwell_timer #(
      .DWELL_CYC (DWELL_CYC)
   ) u_dwell (
      .clk       (clk),
      .rst_n     (rst_n),
      .band      (band),
      .step_vld  (step_vld),
      .step_band (step_band)
   );

   // Near-full slows the producer and near-empty slows the consumer.
   // The opposite band restores each one.
   assign dom_step[DOM_PROD] = step_vld && (step_band == BAND_FULL);
   assign dom_step[DOM_CONS] = step_vld && (step_band == BAND_EMPTY);
   assign dom_rest[DOM_PROD] = (band == BAND_EMPTY);
   assign dom_rest[DOM_CONS] = (band == BAND_FULL);

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      dom_level u_lvl (
         .clk       (clk),
         .rst_n     (rst_n),
         .step      (dom_step[d]),
         .restore   (dom_rest[d]),
         .floor_lvl (floor_lvl),
         .lvl       (dom_lvl[d]),
         .changed   (dom_chg[d])
      );
   end

   stall_timer #(
      .STALL_W (STALL_W)
   ) u_stall (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (|dom_chg),
      .len   (stall_len),
      .stall (stall)
   );

   assign prod_lvl = dom_lvl[DOM_PROD];
   assign cons_lvl = dom_lvl[DOM_CONS];

   // R9
   stall_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((prod_lvl != $past(prod_lvl) || cons_lvl != $past(cons_lvl)) && ($past(stall_len) != '0))
      |-> stall);

   // R10
   stall_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(stall) && prod_lvl == $past(prod_lvl) && cons_lvl == $past(cons_lvl)) |-> !stall);

   // R3
   one_side_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (band == BAND_FULL) |=> (cons_lvl == LVL_FULL));

   // R4
   other_side_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (band == BAND_EMPTY) |=> (prod_lvl == LVL_FULL));

endmodule

// File: tb/sim_occ_dvs_ctrl.sv
`timescale 1ns/1ps
module sim_occ_dvs_ctrl;

   localparam int OCC_W   = 8;
   localparam int DWELL   = 20;
   localparam int STALL_W = 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [OCC_W-1:0]   occ = 8'd50;
   logic [OCC_W-1:0]   cap = 8'd100;
   logic [3:0]         floor_lvl = 4'd5;
   logic [STALL_W-1:0] stall_len = 8'd5;
   logic [3:0]         prod_lvl;
   logic [3:0]         cons_lvl;
   logic               stall;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   int c0      = 0;
   bit done    = 1'b0;

   typedef struct {
      int    at;
      int    p;
      int    c;
      bit    s;
      string req;
   } exp_t;

   exp_t sb[$];

   always #2.5 clk = ~clk;

   occ_dvs_ctrl #(
      .OCC_W     (OCC_W),
      .DWELL_CYC (DWELL),
      .STALL_W   (STALL_W)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .occ       (occ),
      .cap       (cap),
      .floor_lvl (floor_lvl),
      .stall_len (stall_len),
      .prod_lvl  (prod_lvl),
      .cons_lvl  (cons_lvl),
      .stall     (stall)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: compare scheduled expectations away from the active edge
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].at <= cyc) begin
         exp_t e;
         e = sb.pop_front();
         n_tests++;
         if (e.at < cyc) begin
            n_fail++;
            $display("FAIL %s: check for cycle %0d missed (now %0d), expected prod=%0d cons=%0d stall=%0d",
                     e.req, e.at, cyc, e.p, e.c, e.s);
         end else if (prod_lvl != 4'(e.p) || cons_lvl != 4'(e.c) || stall != e.s) begin
            n_fail++;
            $display("FAIL %s @%0d: actual prod=%0d cons=%0d stall=%0d, expected prod=%0d cons=%0d stall=%0d",
                     e.req, cyc, prod_lvl, cons_lvl, stall, e.p, e.c, e.s);
         end
      end
   end

   // Driver helpers
   task automatic mark();
      c0 = cyc;
   endtask

   task automatic expect_at(input int d, input int p, input int c, input bit s, input string req);
      exp_t e;
      e.at = c0 + d; e.p = p; e.c = c; e.s = s; e.req = req;
      sb.push_back(e);
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual run still going at cycle %0d, expected end", cyc);
      finish_up();
   end

   initial begin
      run(3);
      mark();
      rst_n = 1'b1;
      // R1: reset levels
      expect_at(1, 10, 10, 0, "R1");
      run(3);

      // R2 R3 R6 R9: near-full at 95/100 steps the producer twice
      occ = 8'd95; mark();
      expect_at(19, 10, 10, 0, "R3");
      expect_at(20, 9, 10, 1, "R3");
      expect_at(24, 9, 10, 1, "R9");
      expect_at(25, 9, 10, 0, "R9");
      expect_at(39, 9, 10, 0, "R6");
      expect_at(40, 8, 10, 1, "R6");
      run(41);
      occ = 8'd50;
      run(2);

      // R5: an interruption discards the run
      occ = 8'd95; run(10);
      occ = 8'd50; run(1);
      occ = 8'd95; mark();
      expect_at(19, 8, 10, 0, "R5");
      expect_at(20, 7, 10, 1, "R5");
      run(21);

      // R8 R4 R7 R10: near-empty (10/100) restores producer then steps consumer
      occ = 8'd10; floor_lvl = 4'd8; mark();
      expect_at(1, 10, 10, 1, "R8");
      expect_at(19, 10, 10, 0, "R4");
      expect_at(20, 10, 9, 1, "R4");
      expect_at(40, 10, 8, 1, "R4");
      expect_at(45, 10, 8, 0, "R9");
      expect_at(60, 10, 8, 0, "R7");
      expect_at(61, 10, 8, 0, "R10");
      run(62);

      // R8 R2: 90/100 is near-full; consumer restored, producer steps
      floor_lvl = 4'd5;
      occ = 8'd90; mark();
      expect_at(1, 10, 10, 1, "R8");
      expect_at(19, 10, 10, 0, "R2");
      expect_at(20, 9, 10, 1, "R2");
      run(21);

      // R2: 89 and 11 are outside both bands
      occ = 8'd89; mark();
      expect_at(30, 9, 10, 0, "R2");
      run(31);
      occ = 8'd11; mark();
      expect_at(30, 9, 10, 0, "R2");
      run(31);

      // R9: zero settle length gives no stall
      stall_len = 8'd0;
      occ = 8'd95; mark();
      expect_at(19, 9, 10, 0, "R9");
      expect_at(20, 8, 10, 0, "R9");
      run(21);
      occ = 8'd50;
      run(2);

      // R9: change during a stall reloads the full length
      stall_len = 8'd30;
      occ = 8'd95; mark();
      expect_at(20, 7, 10, 1, "R9");
      expect_at(40, 6, 10, 1, "R9");
      expect_at(50, 6, 10, 1, "R9");
      expect_at(69, 6, 10, 1, "R9");
      expect_at(70, 6, 10, 0, "R9");
      run(41);
      occ = 8'd50;
      run(30);

      // R2 R7: cap 0 with occ 0 counts as near-full; floor 5 stops the producer
      stall_len = 8'd5;
      cap = 8'd0; occ = 8'd0; mark();
      expect_at(1, 6, 10, 0, "R2");
      expect_at(20, 5, 10, 1, "R2");
      expect_at(40, 5, 10, 0, "R7");
      run(41);
      run(2);

      if (sb.size() != 0) begin
         n_tests++;
         n_fail++;
         $display("FAIL scoreboard: actual %0d checks left, expected 0", sb.size());
      end
      finish_up();
   end

endmodule